// File: doc/BRIEF.md
# Split Transaction Sequence Tracker

This block sits on the requester side of a bus that multiplexes address and data and supports split transactions. When a read-type request goes out, the block gives it a sequence tag. If the target answers with a split response, the tag stays reserved until the target has returned all of the requested bytes. The target returns those bytes in one or more completion writes that it starts itself. A completion is accepted only when its requester identity matches the local identity and its tag is waiting for data. The block subtracts each completion's partial byte count from the request's total. It retires the sequence, and pulses a done output with the tag, when the last byte arrives.

The tracker has eight slots, one for each value of a 3-bit tag. Each slot is a small state machine with three states. `ST_IDLE` means the tag is free. `ST_ISSUED` means a request carries the tag and the bus outcome is not yet known. `ST_AWAIT` means the request was split and is waiting for completions. The transitions are:
- alloc: `ST_IDLE`→`ST_ISSUED`
- split: `ST_ISSUED`→`ST_AWAIT`
- immediate: `ST_ISSUED`→`ST_IDLE`
- partial: `ST_AWAIT`→`ST_AWAIT`
- finish: `ST_AWAIT`→`ST_IDLE`
- overrun: `ST_AWAIT`→`ST_IDLE`

A combinational picker always offers the lowest free tag.

Top module: `split_seq_tracker`

## Requirements
- R1: After reset every tag is free. `free_tag` is 0, and `tags_full`, `done_valid` and all three error outputs are 0.
- R2: `free_tag` shows the lowest free tag. `tags_full` is 1 only when all 8 tags are in use. A request issued while `tags_full` is 1 is ignored.
- R3: A request issued with `iss_memwr`=1 (a memory write) takes no tag and changes no slot.
- R4: A response for an issued tag with `rsp_split`=1 moves that tag to waiting for completions. With `rsp_split`=0 the tag is freed at once.
- R5: A completion accepted for a waiting tag that brings the remaining count exactly to zero sets `done_valid` for one cycle in the cycle after the completion, with `done_tag` equal to that tag. From that cycle on, the tag is free.
- R6: Partial completions for the same tag add up. A completion that leaves a non-zero remainder produces neither done nor an error.
- R7: A completion larger than the remaining count sets `err_overrun` for one cycle in the next cycle. It frees the tag and produces no done pulse.
- R8: A completion is flagged `err_unexp` in the next cycle, and changes no slot, if either of these holds:
  - its `cpl_rid` differs from `local_id`;
  - its tag is not waiting for completions.
- R9: A response for a tag that is not in the issued state sets `err_badrsp` in the next cycle and is otherwise ignored.
- R10: Byte counts from 1 up to 4096 are tracked exactly, including 4096 delivered across several completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_id | input | 16 | Requester identity (bus and device number) of this node |
| iss_valid | input | 1 | A request is being issued this cycle, using `free_tag` |
| iss_memwr | input | 1 | The issued request is a memory write |
| iss_bytes | input | 13 | Total byte count of the issued request (1 to 4096) |
| free_tag | output | 3 | Lowest free tag |
| tags_full | output | 1 | No tag is free |
| rsp_valid | input | 1 | Bus outcome of an issued request is reported |
| rsp_tag | input | 3 | Tag of the reported request |
| rsp_split | input | 1 | 1: split response, 0: request finished on the bus |
| cpl_valid | input | 1 | A completion write arrives |
| cpl_rid | input | 16 | Requester identity carried by the completion |
| cpl_tag | input | 3 | Tag carried by the completion |
| cpl_bytes | input | 13 | Bytes delivered by this completion |
| done_valid | output | 1 | One-cycle pulse: a sequence has fully completed |
| done_tag | output | 3 | Tag of the completed sequence |
| err_unexp | output | 1 | One-cycle pulse: completion was rejected |
| err_overrun | output | 1 | One-cycle pulse: completion exceeded the remaining count |
| err_badrsp | output | 1 | One-cycle pulse: response for a tag that was not issued |

## Verification
The bench first fills all eight tags. It then checks that one more request is ignored, and that freeing a middle tag makes that tag the offered tag again. A design that scanned for the highest free tag, or that still allocated while full, would show a wrong `free_tag`.

It sends a completion whose identity does not match, and then the correct completion. Done must follow only the correct one. A design that subtracted bytes before checking the identity would finish early or never finish.

Two further cases cover the byte counts. A completion larger than the remainder must produce an overrun and no done pulse. A 4096-byte request split into two halves catches a counter one bit too narrow, which would finish after the first half or never.

// File: rtl/sst_pkg.sv
package sst_pkg;
    localparam int TAG_W     = 3;
    localparam int NTAG      = 1 << TAG_W;
    localparam int RID_W     = 16;
    localparam int MAX_BYTES = 4096;
    localparam int CNT_W     = $clog2(MAX_BYTES) + 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUED = 2'd1,
        ST_AWAIT  = 2'd2
    } slot_state_e;
endpackage

// File: rtl/sst_tag_pick.sv
module sst_tag_pick
    import sst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTAG-1:0]  free_vec,
    output logic [TAG_W-1:0] pick_tag,
    output logic             none_free
);
    always_comb begin
        pick_tag = '0;
        for (int i = NTAG - 1; i >= 0; i--) begin
            if (free_vec[i]) pick_tag = TAG_W'(i);
        end
        none_free = (free_vec == '0);
    end

    // R2: the offered tag is free and no lower tag is free
    p_lowest_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !none_free |-> (free_vec[pick_tag] &&
                        ((free_vec & ((NTAG'(1) << pick_tag) - NTAG'(1))) == '0)));
endmodule

// File: rtl/sst_slot.sv
module sst_slot
    import sst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [CNT_W-1:0] alloc_bytes,
    input  logic             rsp_hit,
    input  logic             rsp_split,
    input  logic             cpl_hit,
    input  logic [CNT_W-1:0] cpl_bytes,
    output logic             busy,
    output logic             rsp_ok,
    output logic             cpl_ok,
    output logic             fin_done,
    output logic             fin_ovr
);
    slot_state_e      st, st_nxt;
    logic [CNT_W-1:0] rem, rem_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            rem <= '0;
        end else begin
            st  <= st_nxt;
            rem <= rem_nxt;
        end
    end

    always_comb begin
        st_nxt   = st;
        rem_nxt  = rem;
        rsp_ok   = 1'b0;
        cpl_ok   = 1'b0;
        fin_done = 1'b0;
        fin_ovr  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (alloc) begin
                    st_nxt  = ST_ISSUED;
                    rem_nxt = alloc_bytes;
                end
            end
            ST_ISSUED: begin
                if (rsp_hit) begin
                    rsp_ok = 1'b1;
                    st_nxt = rsp_split ? ST_AWAIT : ST_IDLE;
                end
            end
            ST_AWAIT: begin
                if (cpl_hit) begin
                    cpl_ok = 1'b1;
                    if (cpl_bytes > rem) begin
                        fin_ovr = 1'b1;
                        st_nxt  = ST_IDLE;
                        rem_nxt = '0;
                    end else if (cpl_bytes == rem) begin
                        fin_done = 1'b1;
                        st_nxt   = ST_IDLE;
                        rem_nxt  = '0;
                    end else begin
                        rem_nxt = rem - cpl_bytes;
                    end
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
        busy = (st != ST_IDLE);
    end

    // R10: a live entry always owes between 1 and the maximum byte count
    p_rem_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_AWAIT) |-> (rem != '0 && rem <= CNT_W'(MAX_BYTES)));
    // R4: an entry waiting for data was split out of the issued state
    p_await_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == ST_AWAIT) |-> $past(st == ST_ISSUED && rsp_hit && rsp_split));
endmodule

// File: rtl/split_seq_tracker.sv
module split_seq_tracker
    import sst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      local_id,
    input  logic             iss_valid,
    input  logic             iss_memwr,
    input  logic [12:0]      iss_bytes,
    output logic [2:0]       free_tag,
    output logic             tags_full,
    input  logic             rsp_valid,
    input  logic [2:0]       rsp_tag,
    input  logic             rsp_split,
    input  logic             cpl_valid,
    input  logic [15:0]      cpl_rid,
    input  logic [2:0]       cpl_tag,
    input  logic [12:0]      cpl_bytes,
    output logic             done_valid,
    output logic [2:0]       done_tag,
    output logic             err_unexp,
    output logic             err_overrun,
    output logic             err_badrsp
);
    logic [NTAG-1:0] busy_vec, rsp_ok_vec, cpl_ok_vec, done_vec, ovr_vec;
    logic            do_alloc, rid_match;
    logic [TAG_W-1:0] fin_tag;

    assign do_alloc  = iss_valid && !iss_memwr && !tags_full;
    assign rid_match = (cpl_rid == local_id);

    sst_tag_pick u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .free_vec  (~busy_vec),
        .pick_tag  (free_tag),
        .none_free (tags_full)
    );

    for (genvar g = 0; g < NTAG; g++) begin : g_slot
        sst_slot u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc       (do_alloc && (free_tag == TAG_W'(g))),
            .alloc_bytes (iss_bytes),
            .rsp_hit     (rsp_valid && (rsp_tag == TAG_W'(g))),
            .rsp_split   (rsp_split),
            .cpl_hit     (cpl_valid && rid_match && (cpl_tag == TAG_W'(g))),
            .cpl_bytes   (cpl_bytes),
            .busy        (busy_vec[g]),
            .rsp_ok      (rsp_ok_vec[g]),
            .cpl_ok      (cpl_ok_vec[g]),
            .fin_done    (done_vec[g]),
            .fin_ovr     (ovr_vec[g])
        );
    end

    always_comb begin
        fin_tag = '0;
        for (int i = 0; i < NTAG; i++) begin
            if (done_vec[i]) fin_tag = TAG_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid  <= 1'b0;
            done_tag    <= '0;
            err_unexp   <= 1'b0;
            err_overrun <= 1'b0;
            err_badrsp  <= 1'b0;
        end else begin
            done_valid  <= |done_vec;
            done_tag    <= fin_tag;
            err_unexp   <= cpl_valid && (cpl_ok_vec == '0);
            err_overrun <= |ovr_vec;
            err_badrsp  <= rsp_valid && (rsp_ok_vec == '0);
        end
    end

    // R3: a memory write alone leaves every slot as it was
    p_memwr_noentry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_memwr && !rsp_valid && !cpl_valid) |=> (busy_vec == $past(busy_vec)));
    // R2: with no tag free, an issue alone changes nothing
    p_full_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tags_full && iss_valid && !rsp_valid && !cpl_valid) |=> $stable(busy_vec));
    // R5: the reported tag is already free when done is seen
    p_done_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !busy_vec[done_tag]);
    // R7: an overrun retirement never reports done
    p_ovr_no_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && err_overrun));
    // R8: a rejected completion cannot coincide with a retirement
    p_unexp_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_unexp |-> !(done_valid || err_overrun));
endmodule

// File: tb/split_seq_tracker_tb_top.sv
module split_seq_tracker_tb_top;
    localparam logic [15:0] MY_ID = 16'h2A18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 0, iss_memwr = 0, rsp_valid = 0, rsp_split = 0, cpl_valid = 0;
    logic [12:0] iss_bytes = '0, cpl_bytes = '0;
    logic [2:0]  rsp_tag = '0, cpl_tag = '0, free_tag, done_tag;
    logic [15:0] cpl_rid = '0;
    logic        tags_full, done_valid, err_unexp, err_overrun, err_badrsp;

    int checks = 0, errors = 0;
    logic [2:0] exp_q[$];

    always #2.5 clk = ~clk;

    split_seq_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .local_id(MY_ID),
        .iss_valid(iss_valid), .iss_memwr(iss_memwr), .iss_bytes(iss_bytes),
        .free_tag(free_tag), .tags_full(tags_full),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_split(rsp_split),
        .cpl_valid(cpl_valid), .cpl_rid(cpl_rid), .cpl_tag(cpl_tag), .cpl_bytes(cpl_bytes),
        .done_valid(done_valid), .done_tag(done_tag),
        .err_unexp(err_unexp), .err_overrun(err_overrun), .err_badrsp(err_badrsp)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: every done pulse must match the next expected tag
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst_n && done_valid) begin
                if (exp_q.size() == 0) chk(0, "R5/R6 unexpected done", done_tag, -1);
                else begin
                    logic [2:0] e;
                    e = exp_q.pop_front();
                    chk(done_tag == e, "R5 done_tag", done_tag, e);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        iss_valid = 0; iss_memwr = 0; rsp_valid = 0; cpl_valid = 0;
    endtask

    task automatic issue(input int bytes, input bit mw);
        iss_valid = 1; iss_memwr = mw; iss_bytes = 13'(bytes);
        tick();
    endtask

    task automatic resp(input int tag, input bit split);
        rsp_valid = 1; rsp_tag = 3'(tag); rsp_split = split;
        tick();
    endtask

    task automatic cpl(input logic [15:0] rid, input int tag, input int bytes, input bit will_done);
        cpl_valid = 1; cpl_rid = rid; cpl_tag = 3'(tag); cpl_bytes = 13'(bytes);
        if (will_done) exp_q.push_back(3'(tag));
        tick();
    endtask

    task automatic errs(input bit u, input bit o, input bit b, input string req);
        chk(err_unexp == u, {req, " err_unexp"}, err_unexp, u);
        chk(err_overrun == o, {req, " err_overrun"}, err_overrun, o);
        chk(err_badrsp == b, {req, " err_badrsp"}, err_badrsp, b);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk(free_tag == 0, "R1 free_tag", free_tag, 0);
        chk(!tags_full && !done_valid, "R1 full/done", {tags_full, done_valid}, 0);
        errs(0, 0, 0, "R1");

        // R5 single completion
        issue(64, 0);
        chk(free_tag == 1, "R2 next tag", free_tag, 1);
        resp(0, 1);
        cpl(MY_ID, 0, 64, 1);
        errs(0, 0, 0, "R5");
        chk(free_tag == 0, "R5 tag freed", free_tag, 0);

        // R6 partial completions
        issue(100, 0); resp(0, 1);
        cpl(MY_ID, 0, 40, 0);
        errs(0, 0, 0, "R6 partial");
        chk(free_tag == 1, "R6 still held", free_tag, 1);
        cpl(MY_ID, 0, 60, 1);
        chk(free_tag == 0, "R6 freed", free_tag, 0);

        // R3 memory write takes no tag
        issue(32, 1);
        chk(free_tag == 0, "R3 no entry", free_tag, 0);
        cpl(MY_ID, 0, 32, 0);
        errs(1, 0, 0, "R3/R8 no entry to complete");

        // R8 mismatched requester id leaves entry untouched
        issue(32, 0); resp(0, 1);
        cpl(MY_ID ^ 16'h0100, 0, 32, 0);
        errs(1, 0, 0, "R8 rid mismatch");
        chk(free_tag == 1, "R8 entry kept", free_tag, 1);
        cpl(MY_ID, 5, 8, 0);
        errs(1, 0, 0, "R8 idle tag");
        cpl(MY_ID, 0, 32, 1);
        errs(0, 0, 0, "R8 good after bad");

        // R9 response for a non-issued tag
        resp(3, 1);
        errs(0, 0, 1, "R9 idle tag");
        chk(free_tag == 0, "R9 ignored", free_tag, 0);
        issue(16, 0); resp(0, 1);
        resp(0, 1);
        errs(0, 0, 1, "R9 already split");
        cpl(MY_ID, 0, 16, 1);

        // R4 non-split response frees tag
        issue(16, 0);
        resp(0, 0);
        errs(0, 0, 0, "R4 immediate");
        chk(free_tag == 0, "R4 freed", free_tag, 0);
        cpl(MY_ID, 0, 16, 0);
        errs(1, 0, 0, "R4 no data expected");

        // R7 overrun
        issue(16, 0); resp(0, 1);
        cpl(MY_ID, 0, 20, 0);
        errs(0, 1, 0, "R7 overrun");
        chk(free_tag == 0, "R7 freed", free_tag, 0);

        // R2 fill all tags
        for (int i = 0; i < 8; i++) begin
            chk(free_tag == 3'(i), "R2 lowest", free_tag, i);
            issue(8, 0);
        end
        chk(tags_full == 1, "R2 full", tags_full, 1);
        issue(8, 0);
        chk(tags_full == 1, "R2 issue while full", tags_full, 1);
        resp(5, 0);
        chk(!tags_full && free_tag == 5, "R2 middle freed", free_tag, 5);

        // R10 maximum byte count in two halves
        issue(4096, 0); resp(5, 1);
        cpl(MY_ID, 5, 2048, 0);
        errs(0, 0, 0, "R10 half");
        chk(tags_full == 1, "R10 still held", tags_full, 1);
        cpl(MY_ID, 5, 2048, 1);
        chk(free_tag == 5, "R10 retired", free_tag, 5);

        repeat (3) tick();
        chk(exp_q.size() == 0, "R5 all done seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule